// File: doc/BRIEF.md
# Vertical Sync Loss Detector with Free-Running Field Reference

This block watches a vertical sync input and counts elapsed time in horizontal line periods, given as a one-clock line tick. While vertical sync keeps arriving, every rising edge of the sync input produces a field-start reference pulse, and the block reports a locked state. If no sync edge is seen for a timeout that depends on the selected TV standard, the block declares loss of signal. A panel timing generator downstream can then keep the panel AC-driven from internal counters alone.

Once loss of signal is declared, an auxiliary line counter takes over as the vertical reference. This counter is restarted by every sync edge and wraps with a period that also depends on the standard. Free-running field pulses begin at the first wrap after the declaration, so the current field finishes before they start. During loss of signal the enable of the horizontal phase-comparator output is dropped, so that output floats and no false phase error reaches the loop filter. The first sync edge that arrives afterwards ends the loss state and re-aligns both counters to itself.

Top module: `fieldref_watchdog`

## Requirements
- R1: While `clr_n` is low, `field_ref`, `no_sig` and `pd_oe` are all 0, and sync edges applied during clear produce no `field_ref` pulse.
- R2: A sync edge is a clock where `vsync_in` is 1 and was 0 on the previous clock. In locked operation each such edge drives `field_ref` high for the following clock.
- R3: With `pal_sel` = 0, `no_sig` is still 0 after the 300th line tick following the last sync edge. It is 1 on the clock after the 301st. The line tick that carries the edge counts as tick 0.
- R4: With `pal_sel` = 1, the same rule applies with 359 ticks (still 0) and 360 ticks (1).
- R5: Each sync edge restarts the timeout count. Edges spaced 290 line ticks apart never raise `no_sig` in either standard.
- R6: `pd_oe` is 0 whenever `no_sig` is 1. It is 1 from the first clock after clear while no loss is declared.
- R7: With `pal_sel` = 0 and no sync, free-running `field_ref` pulses appear on the clock after line ticks 538, 807, 1076 and so on, counted from the last edge. These are multiples of 269 ticks beyond the 301-tick timeout.
- R8: With `pal_sel` = 1 and no sync, free-running pulses appear after ticks 642, 963 and so on. These are multiples of 321 ticks beyond the 360-tick timeout.
- R9: A sync edge while `no_sig` is 1 clears `no_sig` on the next clock and raises `field_ref` for that clock. It also restarts the auxiliary count, so no free pulse follows while sync stays present.
- R10: `field_ref` is never high except after a sync edge (R2, R9) or at a free-running position (R7, R8). Auxiliary wraps during locked operation produce no pulse.
- R11: Every `field_ref` pulse is exactly one clock wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| clr_n | input | 1 | Active-low asynchronous clear of all state |
| line_tick | input | 1 | One-clock pulse per horizontal line period |
| vsync_in | input | 1 | Vertical sync, active high; rising edge marks a field |
| pal_sel | input | 1 | Standard select: 0 selects the 525-line constants, 1 the 625-line constants |
| field_ref | output | 1 | One-clock field-start reference pulse |
| no_sig | output | 1 | High while loss of vertical sync is declared |
| pd_oe | output | 1 | Output enable for the phase-comparator driver; low means high impedance |

## Verification
The bench builds the block with its default constants: periods of 269 and 321 lines and timeouts of 301 and 360 lines. It issues one line tick every four clocks. At these values a complete timeout and three free-running fields per standard fit in roughly fifteen thousand clocks. The exact tick at which `no_sig` rises, the delayed start of free running and the re-alignment on recovery are therefore all reached with real values, not scaled-down ones.

// File: rtl/fieldref_pkg.sv
package fieldref_pkg;

  // Choose the standard-dependent constant; kept as a function so the
  // bench can restate the same selection in its own terms.
  function automatic int unsigned pick_limit(input logic pal,
                                             input int unsigned v525,
                                             input int unsigned v625);
    return pal ? v625 : v525;
  endfunction

  function automatic int unsigned max2(input int unsigned a,
                                       input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fr_vsync_edge.sv
module fr_vsync_edge (
  input  logic clk,
  input  logic clr_n,
  input  logic vsync_in,
  output logic vs_edge
);
  logic vs_prev;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) vs_prev <= 1'b0;
    else        vs_prev <= vsync_in;
  end

  assign vs_edge = clr_n & vsync_in & ~vs_prev;
endmodule

// File: rtl/fr_loss_timer.sv
module fr_loss_timer
  import fieldref_pkg::*;
#(
  parameter int unsigned TO_525 = 301,
  parameter int unsigned TO_625 = 360,
  parameter int unsigned CW     = 9
) (
  input  logic clk,
  input  logic clr_n,
  input  logic line_tick,
  input  logic restart,
  input  logic pal_sel,
  output logic expire
);
  localparam int unsigned TO_MAX = max2(TO_525, TO_625);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic [CW:0]   cnt_inc;

  assign lim     = CW'(pick_limit(pal_sel, TO_525, TO_625));
  assign cnt_inc = {1'b0, cnt} + (CW+1)'(1);
  assign expire  = line_tick & ~restart & (cnt_inc >= {1'b0, lim});

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)                              cnt <= '0;
    else if (restart)                        cnt <= '0;
    else if (line_tick && cnt < CW'(TO_MAX)) cnt <= cnt_inc[CW-1:0];
  end

  // R3
  to_bound_chk: assert property (@(posedge clk) disable iff (!clr_n)
    cnt <= CW'(TO_MAX))
    else $error("timeout count beyond limit");
endmodule

// File: rtl/fr_aux_counter.sv
module fr_aux_counter
  import fieldref_pkg::*;
#(
  parameter int unsigned PER_525 = 269,
  parameter int unsigned PER_625 = 321,
  parameter int unsigned CW      = 9
) (
  input  logic clk,
  input  logic clr_n,
  input  logic line_tick,
  input  logic realign,
  input  logic pal_sel,
  output logic wrap
);
  localparam int unsigned PER_MAX = max2(PER_525, PER_625);

  logic [CW-1:0] cnt;
  logic [CW-1:0] per;
  logic [CW:0]   cnt_inc;

  assign per     = CW'(pick_limit(pal_sel, PER_525, PER_625));
  assign cnt_inc = {1'b0, cnt} + (CW+1)'(1);
  assign wrap    = line_tick & ~realign & (cnt_inc >= {1'b0, per});

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)         cnt <= '0;
    else if (realign)   cnt <= '0;
    else if (wrap)      cnt <= '0;
    else if (line_tick) cnt <= cnt_inc[CW-1:0];
  end

  // R7
  aux_bound_chk: assert property (@(posedge clk) disable iff (!clr_n)
    cnt < CW'(PER_MAX))
    else $error("auxiliary count beyond period");
endmodule

// File: rtl/fieldref_watchdog.sv
module fieldref_watchdog
  import fieldref_pkg::*;
#(
  parameter int unsigned PER_525 = 269,
  parameter int unsigned PER_625 = 321,
  parameter int unsigned TO_525  = 301,
  parameter int unsigned TO_625  = 360
) (
  input  logic clk,
  input  logic clr_n,
  input  logic line_tick,
  input  logic vsync_in,
  input  logic pal_sel,
  output logic field_ref,
  output logic no_sig,
  output logic pd_oe
);
  localparam int unsigned SPAN = max2(max2(PER_525, PER_625),
                                      max2(TO_525, TO_625));
  localparam int unsigned CW   = $clog2(SPAN + 1);

  // Named internal events, visible to the assertions below.
  logic vs_edge;
  logic expire;
  logic aux_wrap;
  logic no_sig_nxt;

  fr_vsync_edge u_edge (
    .clk      (clk),
    .clr_n    (clr_n),
    .vsync_in (vsync_in),
    .vs_edge  (vs_edge)
  );

  fr_loss_timer #(.TO_525(TO_525), .TO_625(TO_625), .CW(CW)) u_timer (
    .clk       (clk),
    .clr_n     (clr_n),
    .line_tick (line_tick),
    .restart   (vs_edge),
    .pal_sel   (pal_sel),
    .expire    (expire)
  );

  fr_aux_counter #(.PER_525(PER_525), .PER_625(PER_625), .CW(CW)) u_aux (
    .clk       (clk),
    .clr_n     (clr_n),
    .line_tick (line_tick),
    .realign   (vs_edge),
    .pal_sel   (pal_sel),
    .wrap      (aux_wrap)
  );

  // A sync edge always wins over a timeout in the same clock.
  assign no_sig_nxt = vs_edge ? 1'b0 : (expire | no_sig);

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      no_sig    <= 1'b0;
      field_ref <= 1'b0;
      pd_oe     <= 1'b0;
    end else begin
      no_sig    <= no_sig_nxt;
      field_ref <= vs_edge | (aux_wrap & no_sig);
      pd_oe     <= ~no_sig_nxt;
    end
  end

  // R9
  recover_chk: assert property (@(posedge clk) disable iff (!clr_n)
    vs_edge |=> !no_sig)
    else $error("sync edge did not end loss state");

  // R3
  declare_chk: assert property (@(posedge clk) disable iff (!clr_n)
    $rose(no_sig) |-> !$past(vs_edge))
    else $error("loss declared on a sync edge");

  // R6
  pd_oe_chk: assert property (@(posedge clk) disable iff (!clr_n)
    no_sig |-> !pd_oe)
    else $error("phase output enabled during loss");

  // R10
  free_pulse_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (field_ref && !$past(vs_edge)) |-> ($past(no_sig) && $past(aux_wrap)))
    else $error("field pulse without edge or free-run wrap");
endmodule

// File: tb/fieldref_watchdog_tb.sv
module fieldref_watchdog_tb_top;
  logic clk = 1'b0;
  logic clr_n, line_tick, vsync_in, pal_sel;
  logic field_ref, no_sig, pd_oe;

  always #4 clk = ~clk;

  fieldref_watchdog dut_i (
    .clk       (clk),
    .clr_n     (clr_n),
    .line_tick (line_tick),
    .vsync_in  (vsync_in),
    .pal_sel   (pal_sel),
    .field_ref (field_ref),
    .no_sig    (no_sig),
    .pd_oe     (pd_oe)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_run = 0;
  int n_fail = 0;
  int exp_q[$];
  string tag_q[$];
  int k = 0;
  bit prev_fr = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pops expected pulse cycles as the design produces pulses.
  always @(negedge clk) begin
    if (exp_q.size() > 0 && exp_q[0] < cyc) begin
      check(1'b0, tag_q[0], -1, exp_q[0]);
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
    if (field_ref) begin
      if (exp_q.size() > 0 && exp_q[0] == cyc) begin
        check(1'b1, tag_q[0], cyc, exp_q[0]);
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end else begin
        check(1'b0, "R10", cyc, -1);
      end
      check(!prev_fr, "R11", 2, 1);
    end
    prev_fr = field_ref;
  end

  // Driver: one line period is four clocks; the tick is the first clock.
  task automatic line(input bit vs, input bit chk, input string tag);
    int per;
    int to;
    bit e;
    per = pal_sel ? 321 : 269;
    to  = pal_sel ? 360 : 301;
    line_tick = 1'b1;
    vsync_in  = vs;
    if (vs) begin
      k = 0;
      exp_q.push_back(cyc + 1);
      tag_q.push_back(tag);
    end else begin
      k++;
      if (k % per == 0 && k > to) begin
        exp_q.push_back(cyc + 1);
        tag_q.push_back(pal_sel ? "R8" : "R7");
      end
    end
    @(negedge clk);
    line_tick = 1'b0;
    vsync_in  = 1'b0;
    if (chk) begin
      e = !vs && (k >= to);
      check(no_sig == e, tag, no_sig, e);
      check(pd_oe == !e, "R6", pd_oe, !e);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) line(1'b0, 1'b0, "");
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog (all requirements)", 0, 1);
    summary();
    $finish;
  end

  initial begin
    clr_n = 1'b0; line_tick = 1'b0; vsync_in = 1'b0; pal_sel = 1'b0;
    repeat (2) @(negedge clk);
    // R1: edges and ticks during clear leave everything low
    line_tick = 1'b1; vsync_in = 1'b1;
    @(negedge clk);
    line_tick = 1'b0; vsync_in = 1'b0;
    @(negedge clk);
    check(field_ref == 1'b0, "R1", field_ref, 0);
    check(no_sig == 1'b0, "R1", no_sig, 0);
    check(pd_oe == 1'b0, "R1", pd_oe, 0);
    clr_n = 1'b1;
    k = 0;
    @(negedge clk);
    check(pd_oe == 1'b1, "R6", pd_oe, 1);
    repeat (2) @(negedge clk);

    // R2, R5, R10: locked 525-line operation, edges 290 lines apart
    for (int f = 0; f < 4; f++) begin
      line(1'b1, 1'b1, "R2");
      idle(288);
      line(1'b0, 1'b1, "R5");
    end

    // R3, R7: loss of sync in 525-line mode
    line(1'b1, 1'b1, "R2");
    idle(299);
    line(1'b0, 1'b1, "R3");
    line(1'b0, 1'b1, "R3");
    idle(799);

    // R9: recovery, then no free pulse while sync returns
    line(1'b1, 1'b1, "R9");
    idle(279);
    line(1'b0, 1'b1, "R9");
    line(1'b1, 1'b1, "R9");

    // R4, R8, R5: 625-line operation
    pal_sel = 1'b1;
    line(1'b1, 1'b1, "R2");
    idle(288);
    line(1'b0, 1'b1, "R5");
    line(1'b1, 1'b1, "R2");
    idle(357);
    line(1'b0, 1'b1, "R4");
    line(1'b0, 1'b1, "R4");
    idle(640);

    // R1: clear during loss of signal
    clr_n = 1'b0;
    @(negedge clk);
    check(field_ref == 1'b0, "R1", field_ref, 0);
    check(no_sig == 1'b0, "R1", no_sig, 0);
    check(pd_oe == 1'b0, "R1", pd_oe, 0);
    clr_n = 1'b1;
    k = 0;
    @(negedge clk);
    check(pd_oe == 1'b1, "R6", pd_oe, 1);
    idle(10);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R7", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule